// File: doc/BRIEF.md
# Predicated Indexed Vector Load Sequencer

This block walks one register-plus-register indexed load across a short vector. A start pulse captures a configuration: a destination register, a base register, an offset register, a vector/scalar flag for each of the three, an address write-back flag, a vector length, and two predicate masks. The source mask gates the base and offset elements and the destination mask gates the destination elements. For each element the block reads the base and offset registers in one cycle through two read ports. It adds them to form a memory address, issues one read and writes the returned word into the destination register. With write-back enabled, it also stores the address into the base register it read from.

The three element indices are separate cursors. Each one advances only for an operand marked as a vector, and each one skips masked-off elements on its own. The sequence stops in one of three ways: after the first load when the destination is scalar, after the first load when both address operands are scalar, or when some vector cursor has no enabled element left below the vector length. A one-cycle done pulse marks the end.

The memory side has two valid/ready channels. The request channel carries an address. Once `req_valid` is high, the address and valid are held until `req_ready` is seen high at a clock edge. The response channel carries the read data. `rsp_ready` is high only while a request is outstanding, so at most one read is in flight and a response offered at any other time is not taken. The register file is external. Its read ports are combinational, and its single write port is sampled at the clock edge.

Top module: `idx_load_seq`

## Requirements
- R1: Each element's address is the sum, modulo 2^AW, of the register at (base + base index) and the register at (offset + offset index). Register numbers wrap modulo RN, and RN is a power of two. Both registers are read in the same cycle as the request.
- R2: When the base operand is a vector, its index moves to the next element whose source predicate bit (bit n for element n) is 1. When the base operand is scalar, its index stays 0 and the mask is ignored.
- R3: When the offset operand is a vector, its index skips elements by the same source predicate, independently of the base index. When it is scalar, its index stays 0.
- R4: When the destination is a vector, its index skips elements whose destination predicate bit is 0. The loaded word is written to register (destination + destination index).
- R5: With write-back enabled, the address is written to register (base + base index) in the cycle the request is accepted. The loaded word is written later, so it wins if the two registers coincide.
- R6: A scalar destination ends the sequence after exactly one load.
- R7: When both the base and offset operands are scalar, the sequence ends after exactly one load.
- R8: After each load, every vector cursor moves one element past the one just used. The sequence ends without a further load as soon as any vector cursor has no enabled element below the vector length. This case includes a vector length of 0.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low again. After reset, `busy`, `done`, `req_valid` and `wr_en` are low. A start pulse while `busy` is high is ignored.
- R10: A request holds `req_valid` and `req_addr` stable until it is accepted. `rsp_ready` is high only while a read is outstanding, and it is never high together with `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the configuration and begin, when idle |
| cfg_dst | input | RIW | Destination base register |
| cfg_dst_vec | input | 1 | Destination is a vector |
| cfg_base | input | RIW | Base-address register |
| cfg_base_vec | input | 1 | Base operand is a vector |
| cfg_offs | input | RIW | Offset register |
| cfg_offs_vec | input | 1 | Offset operand is a vector |
| cfg_upd | input | 1 | Write the address back to the base register |
| cfg_vlen | input | IW | Vector length, 0 to MAXVL |
| src_pred | input | MAXVL | Source predicate mask |
| dst_pred | input | MAXVL | Destination predicate mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rd0_idx | output | RIW | Register read port 0 index (base) |
| rd0_data | input | AW | Register read port 0 data |
| rd1_idx | output | RIW | Register read port 1 index (offset) |
| rd1_data | input | AW | Register read port 1 data |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | RIW | Register write index |
| wr_data | output | AW | Register write data |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory read request ready |
| req_addr | output | AW | Memory read address |
| rsp_valid | input | 1 | Memory read response valid |
| rsp_ready | output | 1 | Memory read response ready |
| rsp_data | input | AW | Memory read response data |

## Verification
The hardest situation to reach from the ports has three parts at once: two vector cursors drifting apart under different masks, write-back changing a register that a later element reads as its base or offset, and the destination range overlapping both. The stimulus reaches it by sweeping every combination of the three vector flags and the write-back flag against several vector lengths and mask pairs. The base, offset and destination ranges are placed so that they overlap and wrap. The memory side applies pseudo-random request and response stalls throughout. One run aims the destination at the base register, to pin down the write order.

// File: rtl/idx_load_pkg.sv
package idx_load_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  localparam int NUM_CURSORS = 3;
  localparam int CUR_BASE = 0;
  localparam int CUR_OFFS = 1;
  localparam int CUR_DST  = 2;
endpackage

// File: rtl/elem_cursor.sv
module elem_cursor #(
  parameter int MAXVL = 8,
  parameter int IW    = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             is_vec,
  input  logic [MAXVL-1:0] mask,
  input  logic [IW-1:0]    vlen,
  output logic [IW-1:0]    cur,
  output logic             spent
);
  logic [IW-1:0] pos_q;

  // first enabled element at or above the raw position, below vlen
  always_comb begin
    cur = is_vec ? vlen : '0;
    if (is_vec) begin
      for (int p = MAXVL - 1; p >= 0; p--) begin
        if (mask[p] && (IW'(p) >= pos_q) && (IW'(p) < vlen)) cur = IW'(p);
      end
    end
  end

  assign spent = is_vec && (cur >= vlen);

  always_ff @(posedge clk) begin
    if (!rst_n)               pos_q <= '0;
    else if (clear)           pos_q <= '0;
    else if (step && is_vec)  pos_q <= cur + IW'(1);
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW  = 16,
  parameter int RIW = 4,
  parameter int IW  = 4
) (
  input  logic [RIW-1:0] base_r,
  input  logic [RIW-1:0] offs_r,
  input  logic [RIW-1:0] dst_r,
  input  logic [IW-1:0]  base_i,
  input  logic [IW-1:0]  offs_i,
  input  logic [IW-1:0]  dst_i,
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  offs_val,
  output logic [RIW-1:0] base_idx,
  output logic [RIW-1:0] offs_idx,
  output logic [RIW-1:0] dst_idx,
  output logic [AW-1:0]  ea
);
  assign base_idx = base_r + RIW'(base_i);
  assign offs_idx = offs_r + RIW'(offs_i);
  assign dst_idx  = dst_r  + RIW'(dst_i);
  assign ea       = base_val + offs_val;
endmodule

// File: rtl/idx_load_seq.sv
module idx_load_seq
  import idx_load_pkg::*;
#(
  parameter int AW    = 16,
  parameter int RN    = 16,
  parameter int MAXVL = 8,
  localparam int RIW  = $clog2(RN),
  localparam int IW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RIW-1:0]   cfg_dst,
  input  logic             cfg_dst_vec,
  input  logic [RIW-1:0]   cfg_base,
  input  logic             cfg_base_vec,
  input  logic [RIW-1:0]   cfg_offs,
  input  logic             cfg_offs_vec,
  input  logic             cfg_upd,
  input  logic [IW-1:0]    cfg_vlen,
  input  logic [MAXVL-1:0] src_pred,
  input  logic [MAXVL-1:0] dst_pred,
  output logic             busy,
  output logic             done,
  output logic [RIW-1:0]   rd0_idx,
  input  logic [AW-1:0]    rd0_data,
  output logic [RIW-1:0]   rd1_idx,
  input  logic [AW-1:0]    rd1_data,
  output logic             wr_en,
  output logic [RIW-1:0]   wr_idx,
  output logic [AW-1:0]    wr_data,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [AW-1:0]    rsp_data
);
  seq_state_e state_q;

  logic [RIW-1:0]   dst_q, base_q, offs_q;
  logic             dst_vec_q, base_vec_q, offs_vec_q, upd_q;
  logic [IW-1:0]    vlen_q;
  logic [MAXVL-1:0] src_q, dpred_q;
  logic             done_q;

  logic                  launch, req_fire, rsp_fire, finish_early, last_elem, advance;
  logic [NUM_CURSORS-1:0] vec_sel, spent;
  logic [MAXVL-1:0]      mask_sel [NUM_CURSORS];
  logic [IW-1:0]         cur      [NUM_CURSORS];
  logic [RIW-1:0]        dst_idx;
  logic [AW-1:0]         ea;

  assign launch       = start && (state_q == ST_IDLE);
  assign finish_early = (state_q == ST_ISSUE) && (|spent);
  assign req_valid    = (state_q == ST_ISSUE) && !finish_early;
  assign req_fire     = req_valid && req_ready;
  assign rsp_ready    = (state_q == ST_WAIT);
  assign rsp_fire     = rsp_valid && rsp_ready;
  assign last_elem    = !dst_vec_q || (!base_vec_q && !offs_vec_q);
  assign advance      = rsp_fire && !last_elem;

  assign vec_sel[CUR_BASE]  = base_vec_q;
  assign vec_sel[CUR_OFFS]  = offs_vec_q;
  assign vec_sel[CUR_DST]   = dst_vec_q;
  assign mask_sel[CUR_BASE] = src_q;
  assign mask_sel[CUR_OFFS] = src_q;
  assign mask_sel[CUR_DST]  = dpred_q;

  for (genvar g = 0; g < NUM_CURSORS; g++) begin : g_cursor
    elem_cursor #(.MAXVL(MAXVL), .IW(IW)) u_cursor (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (launch),
      .step   (advance),
      .is_vec (vec_sel[g]),
      .mask   (mask_sel[g]),
      .vlen   (vlen_q),
      .cur    (cur[g]),
      .spent  (spent[g])
    );
  end

  addr_gen #(.AW(AW), .RIW(RIW), .IW(IW)) u_addr (
    .base_r   (base_q),
    .offs_r   (offs_q),
    .dst_r    (dst_q),
    .base_i   (cur[CUR_BASE]),
    .offs_i   (cur[CUR_OFFS]),
    .dst_i    (cur[CUR_DST]),
    .base_val (rd0_data),
    .offs_val (rd1_data),
    .base_idx (rd0_idx),
    .offs_idx (rd1_idx),
    .dst_idx  (dst_idx),
    .ea       (ea)
  );

  assign req_addr = ea;

  // one write port: address write-back at request accept, load data at response
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rd0_idx;
    wr_data = ea;
    if (req_fire && upd_q) begin
      wr_en = 1'b1;
    end else if (rsp_fire) begin
      wr_en   = 1'b1;
      wr_idx  = dst_idx;
      wr_data = rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      dst_q      <= '0;
      base_q     <= '0;
      offs_q     <= '0;
      dst_vec_q  <= 1'b0;
      base_vec_q <= 1'b0;
      offs_vec_q <= 1'b0;
      upd_q      <= 1'b0;
      vlen_q     <= '0;
      src_q      <= '0;
      dpred_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            dst_q      <= cfg_dst;
            base_q     <= cfg_base;
            offs_q     <= cfg_offs;
            dst_vec_q  <= cfg_dst_vec;
            base_vec_q <= cfg_base_vec;
            offs_vec_q <= cfg_offs_vec;
            upd_q      <= cfg_upd;
            vlen_q     <= cfg_vlen;
            src_q      <= src_pred;
            dpred_q    <= dst_pred;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (finish_early) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (req_fire) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_fire) begin
            if (last_elem) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
endmodule

// File: rtl/idx_load_chk.sv
module idx_load_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !rsp_ready)); // R9

  AST_WRITE_AT_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((req_valid && req_ready) || (rsp_valid && rsp_ready))); // R5
endmodule

bind idx_load_seq idx_load_chk #(.AW(AW)) u_idx_load_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready)
);

// File: tb/test_idx_load_seq.sv
`timescale 1ns/1ps
module test_idx_load_seq;
  localparam int AW    = 16;
  localparam int RN    = 16;
  localparam int MAXVL = 8;
  localparam int RIW   = $clog2(RN);
  localparam int IW    = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic [RIW-1:0]   cfg_dst = '0, cfg_base = '0, cfg_offs = '0;
  logic             cfg_dst_vec = 1'b0, cfg_base_vec = 1'b0, cfg_offs_vec = 1'b0, cfg_upd = 1'b0;
  logic [IW-1:0]    cfg_vlen = '0;
  logic [MAXVL-1:0] src_pred = '0, dst_pred = '0;
  logic             busy, done;
  logic [RIW-1:0]   rd0_idx, rd1_idx, wr_idx;
  logic [AW-1:0]    rd0_data, rd1_data, wr_data, req_addr;
  logic             wr_en, req_valid, rsp_ready;
  logic             req_ready = 1'b0, rsp_valid = 1'b0;
  logic [AW-1:0]    rsp_data = '0;

  idx_load_seq #(.AW(AW), .RN(RN), .MAXVL(MAXVL)) i_idx_load_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_dst(cfg_dst), .cfg_dst_vec(cfg_dst_vec),
    .cfg_base(cfg_base), .cfg_base_vec(cfg_base_vec),
    .cfg_offs(cfg_offs), .cfg_offs_vec(cfg_offs_vec),
    .cfg_upd(cfg_upd), .cfg_vlen(cfg_vlen),
    .src_pred(src_pred), .dst_pred(dst_pred),
    .busy(busy), .done(done),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [AW-1:0] memf(input logic [AW-1:0] a);
    return (a * 16'd7) ^ 16'h3C5A;
  endfunction

  function automatic logic [AW-1:0] init_val(input int r, input int seed);
    return AW'(r * 16'h0123 + seed * 16'h0457 + 16'h0010);
  endfunction

  // register file model
  logic [AW-1:0] rf [RN];
  logic          init_req = 1'b0;
  int            seed = 0;
  assign rd0_data = rf[rd0_idx];
  assign rd1_data = rf[rd1_idx];
  always @(posedge clk) begin
    if (init_req) begin
      for (int r = 0; r < RN; r++) rf[r] <= init_val(r, seed);
    end else if (wr_en) begin
      rf[wr_idx] <= wr_data;
    end
  end

  int checks = 0;
  int errors = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory responder with pseudo-random stalls
  logic [15:0]   lfsr = 16'hACE1;
  int            fired = 0;
  int            overlap = 0;
  logic [AW-1:0] got_addr [16];
  bit            req_fire_f = 0, rsp_fire_f = 0, pending = 0;
  logic [AW-1:0] pend_addr = '0;
  int            delay = 0;

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rsp_fire_f) begin
        rsp_valid = 1'b0;
        pending   = 0;
      end
      if (req_fire_f) begin
        pending   = 1;
        pend_addr = got_addr[(fired - 1) % 16];
        delay     = int'(lfsr[2:0]) % 4;
      end
      if (req_valid && rsp_ready) overlap++;
      req_ready = lfsr[4] | lfsr[7];
      req_fire_f = req_valid && req_ready && rst_n;
      if (req_fire_f) begin
        got_addr[fired % 16] = req_addr;
        fired++;
      end
      if (pending && !rsp_valid) begin
        if (delay == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = memf(pend_addr);
        end else begin
          delay--;
        end
      end
      rsp_fire_f = rsp_valid && rsp_ready;
    end
  end

  // reference model
  logic [AW-1:0] exp_rf   [RN];
  logic [AW-1:0] exp_addr [16];
  int            exp_n;

  task automatic model(input bit dv, bv, ov, up, input int vl,
                       input logic [MAXVL-1:0] sm, dm,
                       input int dst, base, offs, sd);
    int i = 0, k = 0, j = 0;
    logic [AW-1:0] ea;
    for (int r = 0; r < RN; r++) exp_rf[r] = init_val(r, sd);
    exp_n = 0;
    for (int guard = 0; guard <= MAXVL; guard++) begin
      if (bv) while (i < vl && !sm[i]) i++;
      if (ov) while (k < vl && !sm[k]) k++;
      if (dv) while (j < vl && !dm[j]) j++;
      if ((bv && i >= vl) || (ov && k >= vl) || (dv && j >= vl)) break;
      ea = exp_rf[(base + i) % RN] + exp_rf[(offs + k) % RN];
      exp_addr[exp_n] = ea;
      exp_n++;
      if (up) exp_rf[(base + i) % RN] = ea;
      exp_rf[(dst + j) % RN] = memf(ea);
      if (!dv) break;
      if (!bv && !ov) break;
      if (bv) i++;
      if (ov) k++;
      if (dv) j++;
    end
  endtask

  task automatic run_case(input bit dv, bv, ov, up, input int vl,
                          input logic [MAXVL-1:0] sm, dm,
                          input int dst, base, offs, sd, input bit restart);
    string tag_rf, tag_n;
    int wait_cnt;
    bit rf_ok;
    @(negedge clk);
    seed = sd;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    model(dv, bv, ov, up, vl, sm, dm, dst, base, offs, sd);
    cfg_dst_vec = dv; cfg_base_vec = bv; cfg_offs_vec = ov; cfg_upd = up;
    cfg_vlen = IW'(vl); src_pred = sm; dst_pred = dm;
    cfg_dst = RIW'(dst); cfg_base = RIW'(base); cfg_offs = RIW'(offs);
    fired = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      // R9: a start while busy must not disturb the sequence in flight
      chk(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
      cfg_dst = RIW'(dst + 3); cfg_base_vec = ~bv; cfg_upd = ~up;
      cfg_vlen = '0; src_pred = ~sm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_cnt = 0;
    while (!done && wait_cnt < 2000) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9", "done with busy low", {busy, done}, 32'h1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 32'(done), 0);

    if (!dv)            tag_n = "R6";
    else if (!bv && !ov) tag_n = "R7";
    else                tag_n = "R8";
    chk(fired == exp_n, tag_n, "load count", 32'(fired), 32'(exp_n));
    for (int e = 0; e < exp_n && e < fired; e++)
      chk(got_addr[e] == exp_addr[e], "R1", "element address", 32'(got_addr[e]), 32'(exp_addr[e]));

    if (up)                  tag_rf = "R5";
    else if (dv && bv && !ov) tag_rf = "R4";
    else if (bv)             tag_rf = "R2";
    else if (ov)             tag_rf = "R3";
    else                     tag_rf = "R1";
    rf_ok = 1;
    for (int r = 0; r < RN; r++) begin
      if (rf[r] !== exp_rf[r]) begin
        if (rf_ok) chk(0, tag_rf, $sformatf("register %0d", r), 32'(rf[r]), 32'(exp_rf[r]));
        rf_ok = 0;
      end
    end
    if (rf_ok) chk(1, tag_rf, "register file", 0, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [MAXVL-1:0] mset [3];

  initial begin
    mset[0] = 8'hFF;
    mset[1] = 8'b1011_0110;
    mset[2] = 8'b0100_1001;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && req_valid == 1'b0 && wr_en == 1'b0,
        "R9", "reset outputs", {busy, done, req_valid, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9", "idle after reset", {busy, done}, 0);

    // directed: destination collides with base under write-back (R5 ordering)
    run_case(0, 0, 0, 1, 4, 8'hFF, 8'hFF, 5, 5, 11, 3, 0);
    // directed: zero vector length with vector operands ends with no load (R8)
    run_case(1, 1, 1, 0, 0, 8'hFF, 8'hFF, 2, 3, 4, 4, 0);
    // directed: start while busy ignored (R9)
    run_case(1, 1, 0, 1, 6, 8'b1101_1011, 8'b0111_0101, 9, 1, 6, 5, 1);
    // directed: offset-only vector with sparse mask (R3)
    run_case(1, 0, 1, 0, 8, 8'b1000_0010, 8'hFF, 12, 2, 7, 6, 0);

    // sweep of flags, lengths and masks with overlapping, wrapping ranges
    for (int f = 0; f < 16; f++) begin
      for (int v = 0; v < 4; v++) begin
        for (int m = 0; m < 3; m++) begin
          int vl;
          vl = (v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 5 : MAXVL;
          run_case(f[3], f[2], f[1], f[0], vl, mset[m], mset[(m + 1) % 3],
                   9, 1, 6, f * 12 + v * 3 + m, 0);
        end
      end
    end

    chk(overlap == 0, "R10", "request while response pending", 32'(overlap), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule